// File: doc/BRIEF.md
# Conditional Floating-Point Move Predicate

This block decides whether a conditional floating-point register move takes effect or is skipped. It takes a 4-bit condition field and tests it against one of three condition sources: one of four two-bit floating-point condition codes held in a 64-bit status word, one of two integer condition-code nibbles, or a 64-bit signed general register value. A one-hot source-kind input chooses which source is tested.

The result is a single take/skip bit. By default it is registered, so the decision for the inputs presented at one rising clock edge appears after that edge. A parameter selects a purely combinational output instead. The move itself, any status update when a move is skipped, and fetching the register operand all happen outside this block.

Top module: `fmove_predicate`

## Requirements
- R1: On the floating-point path, `fcc_sel` picks the two-bit code from status bits [11:10] for 0, [33:32] for 1, [35:34] for 2 and [37:36] for 3. The code values are 0 equal, 1 less, 2 greater and 3 unordered.
- R2: On the floating-point path, `cond[2:0]` tests the code as follows: 0 never; 1 code not 0; 2 code 1 or 2; 3 code bit 0 set; 4 code 1; 5 code bit 1 set; 6 code 2; 7 code 3.
- R3: On the floating-point and integer paths, `cond[3]`=1 inverts the result of the `cond[2:0]` test. For example, condition 8 always moves.
- R4: On the integer path, `use_xcc`=1 selects `icc[7:4]` and `use_xcc`=0 selects `icc[3:0]`. Within the chosen nibble, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R5: On the integer path, `cond[2:0]` tests: 0 never; 1 Z; 2 Z or (N xor V); 3 N xor V; 4 C or Z; 5 C; 6 N; 7 V.
- R6: On the register path, `reg_val` is a two's-complement signed number. `cond[1:0]` tests: 0 never; 1 equal to zero; 2 less than or equal to zero; 3 less than zero. `cond[2]`=1 inverts the result, and `cond[3]` has no effect.
- R7: `src_kind` is 3'b001 for the floating-point path, 3'b010 for the integer path and 3'b100 for the register path. Any other value gives `take`=0.
- R8: With the default registered output, `take` shows the decision for the inputs sampled at the previous rising edge. Synchronous reset forces `take` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_kind | input | 3 | One-hot condition source selector |
| cond | input | 4 | Condition field |
| fcc_sel | input | 2 | Floating-point condition code selector |
| use_xcc | input | 1 | 1 selects the 64-bit integer flag nibble |
| status | input | 64 | Floating-point status word |
| icc | input | 8 | Integer flags, 64-bit set high, 32-bit set low |
| reg_val | input | 64 | Signed register value |
| take | output | 1 | 1 when the move executes |

## Verification
The floating-point path is swept over every selector, code value and condition. The other three code fields hold different values, so a wrong field choice changes the outcome. The integer path is swept over all 256 flag bytes with both nibble selections and all sixteen conditions; because the two nibbles differ in most patterns, this separates the nibble choice and each flag term. The register path uses zero, plus and minus one, and the extreme signed values, which separate signed from unsigned handling and the three comparisons. Every non-one-hot source value is driven with a condition that would otherwise move, to show that it is forced to a skip.

// File: rtl/fmv_pkg.sv
package fmv_pkg;

    typedef enum logic [2:0] {
        SRC_FLT = 3'b001,
        SRC_INT = 3'b010,
        SRC_REG = 3'b100
    } src_kind_e;

    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } iflags_t;

    localparam int FCC_COUNT = 4;

    // Low bit position of condition code field idx inside the status word.
    function automatic int fcc_lsb(input int idx);
        return (idx == 0) ? 10 : (30 + 2 * idx);
    endfunction

endpackage

// File: rtl/fmv_fcc_eval.sv
module fmv_fcc_eval
    import fmv_pkg::*;
#(
    parameter int STATUS_W = 64
) (
    input  logic [STATUS_W-1:0] status,
    input  logic [1:0]          fcc_sel,
    input  logic [2:0]          test,
    output logic                hit
);
    fcc_e fields [FCC_COUNT];
    fcc_e code;

    for (genvar g = 0; g < FCC_COUNT; g++) begin : g_fld
        localparam int LSB = fcc_lsb(g);
        assign fields[g] = fcc_e'(status[LSB+1:LSB]);
    end

    assign code = fields[fcc_sel];

    always_comb begin
        unique case (test)
            3'd0: hit = 1'b0;
            3'd1: hit = (code != FCC_EQ);
            3'd2: hit = (code == FCC_LT) || (code == FCC_GT);
            3'd3: hit = (code == FCC_LT) || (code == FCC_UN);
            3'd4: hit = (code == FCC_LT);
            3'd5: hit = (code == FCC_GT) || (code == FCC_UN);
            3'd6: hit = (code == FCC_GT);
            default: hit = (code == FCC_UN);
        endcase
    end
endmodule

// File: rtl/fmv_icc_eval.sv
module fmv_icc_eval
    import fmv_pkg::*;
(
    input  logic [7:0] icc,
    input  logic       use_xcc,
    input  logic [2:0] test,
    output logic       hit
);
    iflags_t f;

    assign f = use_xcc ? iflags_t'(icc[7:4]) : iflags_t'(icc[3:0]);

    always_comb begin
        unique case (test)
            3'd0: hit = 1'b0;
            3'd1: hit = f.z;
            3'd2: hit = f.z | (f.n ^ f.v);
            3'd3: hit = f.n ^ f.v;
            3'd4: hit = f.c | f.z;
            3'd5: hit = f.c;
            3'd6: hit = f.n;
            default: hit = f.v;
        endcase
    end
endmodule

// File: rtl/fmv_reg_eval.sv
module fmv_reg_eval #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] value,
    input  logic [1:0]       test,
    output logic             hit
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (value == '0);
    assign is_neg  = value[REG_W-1];

    always_comb begin
        unique case (test)
            2'd0: hit = 1'b0;
            2'd1: hit = is_zero;
            2'd2: hit = is_zero | is_neg;
            default: hit = is_neg;
        endcase
    end
endmodule

// File: rtl/fmove_predicate.sv
module fmove_predicate
    import fmv_pkg::*;
#(
    parameter int STATUS_W = 64,
    parameter int REG_W    = 64,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          src_kind,
    input  logic [3:0]          cond,
    input  logic [1:0]          fcc_sel,
    input  logic                use_xcc,
    input  logic [STATUS_W-1:0] status,
    input  logic [7:0]          icc,
    input  logic [REG_W-1:0]    reg_val,
    output logic                take
);
    logic fcc_hit, icc_hit, reg_hit;
    logic decide;

    fmv_fcc_eval #(.STATUS_W(STATUS_W)) u_fcc (
        .status (status),
        .fcc_sel(fcc_sel),
        .test   (cond[2:0]),
        .hit    (fcc_hit)
    );

    fmv_icc_eval u_icc (
        .icc    (icc),
        .use_xcc(use_xcc),
        .test   (cond[2:0]),
        .hit    (icc_hit)
    );

    fmv_reg_eval #(.REG_W(REG_W)) u_reg (
        .value(reg_val),
        .test (cond[1:0]),
        .hit  (reg_hit)
    );

    always_comb begin
        case (src_kind)
            SRC_FLT: decide = fcc_hit ^ cond[3];
            SRC_INT: decide = icc_hit ^ cond[3];
            SRC_REG: decide = reg_hit ^ cond[2];
            default: decide = 1'b0;
        endcase
    end

    if (REG_OUT) begin : g_reg
        logic take_q;
        always_ff @(posedge clk) begin
            if (rst) take_q <= 1'b0;
            else     take_q <= decide;
        end
        assign take = take_q;

        AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !take); // R8
        AST_BAD_KIND_SKIPS: assert property (@(posedge clk) disable iff (rst)
            ($countones(src_kind) != 1) |=> !take); // R7
        AST_FCC_NEVER: assert property (@(posedge clk) disable iff (rst)
            (src_kind == SRC_FLT && cond == 4'h0) |=> !take); // R2
        AST_FCC_ALWAYS: assert property (@(posedge clk) disable iff (rst)
            (src_kind == SRC_FLT && cond == 4'h8) |=> take); // R3
        AST_INT_EQUAL: assert property (@(posedge clk) disable iff (rst)
            (src_kind == SRC_INT && cond == 4'h1 && (use_xcc ? icc[6] : icc[2])) |=> take); // R5
        AST_REG_ZERO: assert property (@(posedge clk) disable iff (rst)
            (src_kind == SRC_REG && cond[2:0] == 3'b001 && reg_val == '0) |=> take); // R6
    end else begin : g_comb
        assign take = decide;
    end
endmodule

// File: tb/fmove_predicate_bench.sv
module fmove_predicate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_kind = 3'b000;
    logic [3:0]  cond = 4'h0;
    logic [1:0]  fcc_sel = 2'd0;
    logic        use_xcc = 1'b0;
    logic [63:0] status = '0;
    logic [7:0]  icc = '0;
    logic [63:0] reg_val = '0;
    logic        take;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fmove_predicate u_fmove_predicate (
        .clk(clk), .rst(rst), .src_kind(src_kind), .cond(cond),
        .fcc_sel(fcc_sel), .use_xcc(use_xcc), .status(status),
        .icc(icc), .reg_val(reg_val), .take(take)
    );

    function automatic logic model_fcc(input logic [1:0] f, input logic [3:0] c);
        logic r;
        case (c[2:0])
            3'd0: r = 0;
            3'd1: r = (f != 0);
            3'd2: r = (f == 1) || (f == 2);
            3'd3: r = (f == 1) || (f == 3);
            3'd4: r = (f == 1);
            3'd5: r = (f >= 2);
            3'd6: r = (f == 2);
            default: r = (f == 3);
        endcase
        return r ^ c[3];
    endfunction

    function automatic logic model_int(input logic [3:0] nib, input logic [3:0] c);
        logic n, z, v, cy, r;
        n = nib[3]; z = nib[2]; v = nib[1]; cy = nib[0];
        case (c[2:0])
            3'd0: r = 0;
            3'd1: r = z;
            3'd2: r = z || (n != v);
            3'd3: r = (n != v);
            3'd4: r = cy || z;
            3'd5: r = cy;
            3'd6: r = n;
            default: r = v;
        endcase
        return r ^ c[3];
    endfunction

    function automatic logic model_reg(input longint x, input logic [3:0] c);
        logic r;
        case (c[1:0])
            2'd0: r = 0;
            2'd1: r = (x == 0);
            2'd2: r = (x <= 0);
            default: r = (x < 0);
        endcase
        return r ^ c[2];
    endfunction

    task automatic check(input string req, input logic exp);
        @(posedge clk);
        #1;
        checks++;
        if (take !== exp) begin
            errors++;
            $display("FAIL %s kind=%b cond=%h sel=%0d xcc=%b: actual %b expected %b",
                     req, src_kind, cond, fcc_sel, use_xcc, take, exp);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint rv [6];
        rv = '{0, 1, -1, 64'sh7fffffffffffffff, -64'sh7fffffffffffffff - 1, 5};

        // R8: reset state, with inputs that would otherwise move
        src_kind = 3'b001; cond = 4'h8;
        check("R8", 1'b0);
        rst = 1'b0;

        // R1 R2 R3: every selector, code value and condition
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 4; f++)
                for (int c = 0; c < 16; c++) begin
                    logic [63:0] st;
                    st = 64'h0;
                    for (int k = 0; k < 4; k++) begin
                        int lsb;
                        logic [1:0] val;
                        lsb = (k == 0) ? 10 : 30 + 2 * k;
                        val = (k == s) ? 2'(f) : 2'(f + k + 1 - s);
                        if (k != s && val == 2'(f)) val = ~val;
                        st[lsb +: 2] = val;
                    end
                    src_kind = 3'b001; fcc_sel = 2'(s); cond = 4'(c); status = st;
                    check("R1/R2/R3", model_fcc(2'(f), 4'(c)));
                end

        // R4 R5 R3: all flag bytes, both nibble choices, all conditions
        for (int x = 0; x < 2; x++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 16; c++) begin
                    src_kind = 3'b010; use_xcc = x[0]; icc = 8'(b); cond = 4'(c);
                    check("R4/R5", model_int(x[0] ? icc[7:4] : icc[3:0], 4'(c)));
                end

        // R6: signed register tests; cond[3] has no effect
        for (int i = 0; i < 6; i++)
            for (int c = 0; c < 16; c++) begin
                src_kind = 3'b100; reg_val = rv[i]; cond = 4'(c);
                check("R6", model_reg(rv[i], 4'(c)));
            end

        // R7: non-one-hot kinds skip even with always-true conditions
        status = '0; icc = 8'hff; reg_val = '0;
        for (int k = 0; k < 8; k++) begin
            if (k == 1 || k == 2 || k == 4) continue;
            src_kind = 3'(k); cond = 4'h8;
            check("R7", 1'b0);
            cond = 4'h5;
            check("R7", 1'b0);
        end

        // R8: reset mid-stream clears output
        src_kind = 3'b001; cond = 4'h8;
        check("R8", 1'b1);
        rst = 1'b1;
        check("R8", 1'b0);
        rst = 1'b0;
        check("R8", 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule